// File: doc/BRIEF.md
# Indexed Message Bus Bridge

This block gives a host a narrow window onto an internal sideband message bus. The host sees three 32-bit registers: a command word, a payload word and an upper-address word. Writing the command word packs a whole message-bus transaction into one store: the opcode, the target port, the low register offset and the byte enables. That store also launches the transaction.

The upper-address word supplies the offset bits above the 8-bit field in the command word. On a write transaction, the payload word goes out as write data. On a read transaction, the returned word lands in the payload register, where the host can read it back.

The bridge drives a single request/acknowledge pair toward the message bus and allows only one transaction in flight. A busy flag covers the time from launch until acknowledge. A sticky error flag records command stores that were refused, either because the bridge was busy or because the opcode was not legal.

Top module: `mbb_bridge`

## Requirements
- R1: After reset, all three registers read zero, and `busy_o`, `err_o` and `mb_req` are low.
- R2: Register offsets are fixed:
  - byte offset D0h is the command word, which reads back the last accepted value with bits 3:0 forced to zero;
  - D4h is the payload word;
  - D8h is the upper-address word, which reads back the last written value;
  - any other offset reads zero.
- R3: Command word fields are opcode 31:24, port 23:16, low offset 15:8 and byte enables 7:4. An accepted store of a command word with opcode 11h raises `mb_req` at the next clock edge. At that point the bus carries:
  - `mb_opcode` = 11h, together with the port and byte enables from the stored word;
  - `mb_addr` = {upper-address word bits 31:8, low offset};
  - `mb_wdata` = the payload word as it stood at the store.
- R4: Opcode 10h launches a read in the same way. At the clock edge where `mb_ack` is high, the payload register is loaded with `mb_rdata`.
- R5: While `mb_req` is high, all request fields stay stable until `mb_ack` is seen. `mb_req` is low in the cycle after the acknowledge.
- R6: `busy_o` is high from the cycle after launch until the acknowledge edge, and it equals `mb_req`.
- R7: A command store while busy is dropped:
  - the command readback is unchanged;
  - no further request is issued;
  - `err_o` is set.
- R8: A command store with any opcode other than 10h or 11h issues no request and sets `err_o`. Its value is still kept for readback.
- R9: `err_o` stays set until reset, whatever traffic follows.
- R10: Payload stores made while a write is in flight do not change `mb_wdata`. Completing a write leaves the payload register unchanged.
- R11: When a read acknowledge and a host payload store fall in the same cycle, the returned read word wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr_en | input | 1 | Host store strobe |
| host_addr | input | 8 | Host byte offset |
| host_wdata | input | 32 | Host store data |
| host_rdata | output | 32 | Host read data for `host_addr` (combinational) |
| busy_o | output | 1 | A transaction is in flight |
| err_o | output | 1 | Sticky refused-command flag |
| mb_req | output | 1 | Message-bus request |
| mb_opcode | output | 8 | Request opcode |
| mb_port | output | 8 | Request target port |
| mb_addr | output | 32 | Request register offset |
| mb_be | output | 4 | Request byte enables |
| mb_wdata | output | 32 | Request write data |
| mb_ack | input | 1 | Message-bus acknowledge |
| mb_rdata | input | 32 | Message-bus read data, valid with `mb_ack` |

## Verification
Several properties are checked on every cycle:
- the request fields hold stable until acknowledge, and the request falls right after it;
- only legal opcodes ever reach the bus;
- a bad opcode never raises a request;
- a store while busy always sets the error flag, and that flag never clears;
- a read acknowledge always loads the returned word.

Other behaviour can only be shown by the bench's scenarios:
- the exact field unpacking into `mb_addr` and the other request fields;
- readback masking;
- isolation of in-flight write data from later payload stores;
- precedence of the acknowledge over a simultaneous host store.

// File: rtl/mbb_pkg.sv
// Shared constants and request type for the indexed message bus bridge.
// Assumes 32-bit host words and 8-bit opcode/port/offset fields.
package mbb_pkg;
    localparam int MBB_DW     = 32;
    localparam int MBB_FW     = 8;
    localparam int MBB_BEW    = 4;
    localparam int OPC_LSB    = 24;
    localparam int PORT_LSB   = 16;
    localparam int OFS_LSB    = 8;
    localparam int BE_LSB     = 4;
    localparam logic [MBB_FW-1:0] OP_READ  = 8'h10;
    localparam logic [MBB_FW-1:0] OP_WRITE = 8'h11;

    typedef struct packed {
        logic [MBB_FW-1:0]  opcode;
        logic [MBB_FW-1:0]  port;
        logic [MBB_DW-1:0]  addr;
        logic [MBB_BEW-1:0] be;
        logic [MBB_DW-1:0]  wdata;
    } mb_req_t;
endpackage

// File: rtl/mbb_host_regs.sv
// Host-visible register file: command, payload and upper-address words.
// Assumes the command store is qualified by the launch logic (ctrl_accept);
// read data is a combinational function of host_addr.
module mbb_host_regs
    import mbb_pkg::*;
#(
    parameter int          HOST_AW  = 8,
    parameter logic [7:0]  CTRL_OFS = 8'hD0,
    parameter logic [7:0]  DATA_OFS = 8'hD4,
    parameter logic [7:0]  EXT_OFS  = 8'hD8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                host_wr_en,
    input  logic [HOST_AW-1:0]  host_addr,
    input  logic [MBB_DW-1:0]   host_wdata,
    input  logic                ctrl_accept,
    input  logic                rd_load,
    input  logic [MBB_DW-1:0]   rd_word,
    output logic                ctrl_wr,
    output logic [MBB_DW-1:0]   data_q,
    output logic [MBB_DW-1:0]   ext_q,
    output logic [MBB_DW-1:0]   host_rdata
);
    localparam int KEEP_W = MBB_DW - BE_LSB;

    logic [KEEP_W-1:0] ctrl_q;
    logic              data_wr;
    logic              ext_wr;

    // Decode host stores per register.
    assign ctrl_wr = host_wr_en && (host_addr == HOST_AW'(CTRL_OFS));
    assign data_wr = host_wr_en && (host_addr == HOST_AW'(DATA_OFS));
    assign ext_wr  = host_wr_en && (host_addr == HOST_AW'(EXT_OFS));

    // Command word: keep accepted stores, low nibble is not stored.
    always_ff @(posedge clk) begin
        if (!rst_n)           ctrl_q <= '0;
        else if (ctrl_accept) ctrl_q <= host_wdata[MBB_DW-1:BE_LSB];
    end

    // Payload word: read return has priority over a host store.
    always_ff @(posedge clk) begin
        if (!rst_n)       data_q <= '0;
        else if (rd_load) data_q <= rd_word;
        else if (data_wr) data_q <= host_wdata;
    end

    // Upper-address word: plain host register.
    always_ff @(posedge clk) begin
        if (!rst_n)      ext_q <= '0;
        else if (ext_wr) ext_q <= host_wdata;
    end

    // Host read multiplexer.
    always_comb begin
        host_rdata = '0;
        if (host_addr == HOST_AW'(CTRL_OFS))      host_rdata = {ctrl_q, {BE_LSB{1'b0}}};
        else if (host_addr == HOST_AW'(DATA_OFS)) host_rdata = data_q;
        else if (host_addr == HOST_AW'(EXT_OFS))  host_rdata = ext_q;
    end
endmodule

// File: rtl/mbb_launch.sv
// Launch qualifier: accepts command stores when idle, recognises legal
// opcodes and keeps the sticky error flag. Assumes busy comes from the
// request port.
module mbb_launch
    import mbb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic [MBB_FW-1:0] opcode,
    input  logic              busy,
    output logic              ctrl_accept,
    output logic              launch,
    output logic              err
);
    logic op_ok;

    // Qualify the store and the opcode.
    assign op_ok       = (opcode == OP_READ) || (opcode == OP_WRITE);
    assign ctrl_accept = ctrl_wr && !busy;
    assign launch      = ctrl_accept && op_ok;

    // Sticky error on a refused command store.
    always_ff @(posedge clk) begin
        if (!rst_n)                            err <= 1'b0;
        else if (ctrl_wr && (busy || !op_ok))  err <= 1'b1;
    end

    AST_DROP_SETS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && busy) |=> err); // R7
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err); // R9
endmodule

// File: rtl/mbb_req_port.sv
// Request port: holds one message-bus request from launch until acknowledge.
// Assumes launch never arrives while a request is pending.
module mbb_req_port
    import mbb_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    launch,
    input  mb_req_t req_in,
    input  logic    mb_ack,
    output logic    mb_req,
    output mb_req_t req_q,
    output logic    done
);
    // Completion is an acknowledge seen while requesting.
    assign done = mb_req && mb_ack;

    // Request valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n)      mb_req <= 1'b0;
        else if (launch) mb_req <= 1'b1;
        else if (done)   mb_req <= 1'b0;
    end

    // Request fields captured at launch.
    always_ff @(posedge clk) begin
        if (!rst_n)      req_q <= '0;
        else if (launch) req_q <= req_in;
    end

    AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (mb_req && !mb_ack) |=> (mb_req && $stable(req_q))); // R5
    AST_REQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (mb_req && mb_ack) |=> !mb_req); // R5
endmodule

// File: rtl/mbb_bridge.sv
// Top of the indexed message bus bridge. A store to the command word
// launches one message-bus read or write. Field positions come from mbb_pkg.
module mbb_bridge
    import mbb_pkg::*;
#(
    parameter int          HOST_AW  = 8,
    parameter logic [7:0]  CTRL_OFS = 8'hD0,
    parameter logic [7:0]  DATA_OFS = 8'hD4,
    parameter logic [7:0]  EXT_OFS  = 8'hD8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                host_wr_en,
    input  logic [HOST_AW-1:0]  host_addr,
    input  logic [MBB_DW-1:0]   host_wdata,
    output logic [MBB_DW-1:0]   host_rdata,
    output logic                busy_o,
    output logic                err_o,
    output logic                mb_req,
    output logic [MBB_FW-1:0]   mb_opcode,
    output logic [MBB_FW-1:0]   mb_port,
    output logic [MBB_DW-1:0]   mb_addr,
    output logic [MBB_BEW-1:0]  mb_be,
    output logic [MBB_DW-1:0]   mb_wdata,
    input  logic                mb_ack,
    input  logic [MBB_DW-1:0]   mb_rdata
);
    localparam int UP_W = MBB_DW - MBB_FW;

    logic        ctrl_wr, ctrl_accept, launch, done, rd_load;
    logic [MBB_DW-1:0] data_q, ext_q;
    mb_req_t     req_new, req_q;

    // Unpack the command store into a request.
    always_comb begin
        req_new.opcode = host_wdata[OPC_LSB  +: MBB_FW];
        req_new.port   = host_wdata[PORT_LSB +: MBB_FW];
        req_new.addr   = {ext_q[MBB_DW-1 -: UP_W], host_wdata[OFS_LSB +: MBB_FW]};
        req_new.be     = host_wdata[BE_LSB   +: MBB_BEW];
        req_new.wdata  = data_q;
    end

    // A completed read returns its word into the payload register.
    assign rd_load = done && (req_q.opcode == OP_READ);

    mbb_host_regs #(
        .HOST_AW(HOST_AW), .CTRL_OFS(CTRL_OFS), .DATA_OFS(DATA_OFS), .EXT_OFS(EXT_OFS)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .host_wr_en(host_wr_en), .host_addr(host_addr),
        .host_wdata(host_wdata), .ctrl_accept(ctrl_accept), .rd_load(rd_load),
        .rd_word(mb_rdata), .ctrl_wr(ctrl_wr), .data_q(data_q), .ext_q(ext_q),
        .host_rdata(host_rdata)
    );

    mbb_launch u_launch (
        .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .opcode(req_new.opcode),
        .busy(mb_req), .ctrl_accept(ctrl_accept), .launch(launch), .err(err_o)
    );

    mbb_req_port u_port (
        .clk(clk), .rst_n(rst_n), .launch(launch), .req_in(req_new),
        .mb_ack(mb_ack), .mb_req(mb_req), .req_q(req_q), .done(done)
    );

    // Drive the message-bus request fields.
    assign busy_o    = mb_req;
    assign mb_opcode = req_q.opcode;
    assign mb_port   = req_q.port;
    assign mb_addr   = req_q.addr;
    assign mb_be     = req_q.be;
    assign mb_wdata  = req_q.wdata;

    AST_OPCODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        mb_req |-> (mb_opcode == OP_READ || mb_opcode == OP_WRITE)); // R3
    AST_BADOP_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && !mb_req && host_wdata[OPC_LSB +: MBB_FW] != OP_READ
         && host_wdata[OPC_LSB +: MBB_FW] != OP_WRITE) |=> !mb_req); // R8
    AST_READ_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (mb_req && mb_ack && mb_opcode == OP_READ) |=> (data_q == $past(mb_rdata))); // R4
endmodule

// File: tb/mbb_bridge_tb.sv
module mbb_bridge_tb;
    localparam logic [7:0] A_CTRL = 8'hD0, A_DATA = 8'hD4, A_EXT = 8'hD8;

    // Each vector: {command word, payload, upper-address word, read response}.
    localparam logic [127:0] VEC [4] = '{
        {32'h11053CF0, 32'hA5A50001, 32'h00001200, 32'h00000000},
        {32'h101F803F, 32'h11112222, 32'hFFFFFF00, 32'hDEADBEEF},
        {32'h1100FF1A, 32'h000000C3, 32'h80000000, 32'h55555555},
        {32'h10A00180, 32'h00000000, 32'h00000000, 32'h01234567}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr_en = 1'b0;
    logic [7:0]  host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        busy_o, err_o, mb_req, mb_ack = 1'b0;
    logic [7:0]  mb_opcode, mb_port;
    logic [31:0] mb_addr, mb_wdata, mb_rdata = '0;
    logic [3:0]  mb_be;
    int checks = 0, errors = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    mbb_bridge u_dut (
        .clk(clk), .rst_n(rst_n), .host_wr_en(host_wr_en), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .busy_o(busy_o), .err_o(err_o),
        .mb_req(mb_req), .mb_opcode(mb_opcode), .mb_port(mb_port), .mb_addr(mb_addr),
        .mb_be(mb_be), .mb_wdata(mb_wdata), .mb_ack(mb_ack), .mb_rdata(mb_rdata)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic host_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        host_wr_en = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr_en = 1'b0;
    endtask

    task automatic host_read(input logic [7:0] a, output logic [31:0] d);
        host_addr = a; #1; d = host_rdata;
    endtask

    task automatic give_ack(input logic [31:0] r);
        mb_ack = 1'b1; mb_rdata = r;
        @(negedge clk);
        mb_ack = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        do_reset();
        // R1: reset state
        host_read(A_CTRL, rd); chk("R1 ctrl", rd, 0);
        host_read(A_DATA, rd); chk("R1 data", rd, 0);
        host_read(A_EXT, rd);  chk("R1 ext", rd, 0);
        chk("R1 busy/err/req", {29'd0, busy_o, err_o, mb_req}, 0);

        // Table walk: R2 R3 R4 R5 R6
        for (int i = 0; i < 4; i++) begin
            logic [31:0] c, d, e, r;
            {c, d, e, r} = VEC[i];
            host_write(A_EXT, e);
            host_write(A_DATA, d);
            host_write(A_CTRL, c);
            chk("R3 req", {31'd0, mb_req}, 1);
            chk("R6 busy", {31'd0, busy_o}, 1);
            chk("R3 opcode", {24'd0, mb_opcode}, {24'd0, c[31:24]});
            chk("R3 port", {24'd0, mb_port}, {24'd0, c[23:16]});
            chk("R3 addr", mb_addr, {e[31:8], c[15:8]});
            chk("R3 be", {28'd0, mb_be}, {28'd0, c[7:4]});
            if (c[31:24] == 8'h11) chk("R3 wdata", mb_wdata, d);
            repeat (i + 1) @(negedge clk);
            chk("R5 held", {31'd0, mb_req}, 1);
            chk("R5 addr stable", mb_addr, {e[31:8], c[15:8]});
            give_ack(r);
            chk("R5 drop", {31'd0, mb_req}, 0);
            chk("R6 idle", {31'd0, busy_o}, 0);
            host_read(A_DATA, rd);
            if (c[31:24] == 8'h10) chk("R4 read load", rd, r);
            else chk("R10 write keeps data", rd, d);
            host_read(A_CTRL, rd); chk("R2 ctrl readback", rd, {c[31:4], 4'h0});
            host_read(A_EXT, rd);  chk("R2 ext readback", rd, e);
        end
        host_read(8'hDC, rd); chk("R2 unmapped", rd, 0);
        chk("R1 no error yet", {31'd0, err_o}, 0);

        // R10: payload store during in-flight write
        host_write(A_DATA, 32'hCAFE0000);
        host_write(A_CTRL, 32'h11224470);
        host_write(A_DATA, 32'h0BADF00D);
        chk("R10 wdata isolated", mb_wdata, 32'hCAFE0000);
        // R7: command store while busy
        host_write(A_CTRL, 32'h10998810);
        host_read(A_CTRL, rd); chk("R7 ctrl unchanged", rd, 32'h11224470);
        chk("R7 err set", {31'd0, err_o}, 1);
        chk("R7 old req kept", {24'd0, mb_port}, 32'h22);
        give_ack(32'hFFFFFFFF);
        @(negedge clk);
        chk("R7 no new req", {31'd0, mb_req}, 0);
        host_read(A_DATA, rd); chk("R10 data after write", rd, 32'h0BADF00D);

        // R8 / R9: bad opcode after reset
        do_reset();
        host_write(A_CTRL, 32'h22334450);
        chk("R8 no req", {31'd0, mb_req}, 0);
        chk("R8 err", {31'd0, err_o}, 1);
        host_read(A_CTRL, rd); chk("R8 readback", rd, 32'h22334450);
        host_write(A_CTRL, 32'h100101F0);
        chk("R8 later launch ok", {31'd0, mb_req}, 1);

        // R11: read ack coincides with host payload store
        @(negedge clk);
        mb_ack = 1'b1; mb_rdata = 32'h76543210;
        host_wr_en = 1'b1; host_addr = A_DATA; host_wdata = 32'h99999999;
        @(negedge clk);
        mb_ack = 1'b0; host_wr_en = 1'b0;
        host_read(A_DATA, rd); chk("R11 ack wins", rd, 32'h76543210);
        repeat (3) @(negedge clk);
        chk("R9 err sticky", {31'd0, err_o}, 1);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule